// File: doc/BRIEF.md
# DRAM Command Spacing Checker

This block observes the command stream sent to one rank of a DDR3-style memory, one command per clock, and judges each command against the minimum gaps that earlier commands impose. It covers activate, read, write, precharge, mode-register set, refresh and power-down entry. The write-recovery gaps follow the burst mode of each write, because the point at which the internal write begins depends on it. The power-down entry gaps are measured from the read, write and precharge commands that came before.

Each rule has its own down-counter. The counter is armed when the command that starts its window is issued. A command that arrives while any counter that governs it is still running is reported as illegal. Each rule has its own violation bit, so every rule broken on the same command is reported. The write latency and read latency can be changed at run time. The clock period and the nanosecond limits are parameters, and they are turned into whole clocks by rounding up.

Top module: `dram_cmd_spacing_chk`

## Requirements
- R1: Command codes on `cmd_code` are 0 activate, 1 read, 2 write, 3 precharge, 4 mode-register set, 5 refresh, 6 power-down entry and 7 reserved. The verdict for a command with `cmd_valid` high appears on the outputs one clock later with `res_valid` high. `res_legal` is 1 exactly when `res_viol` is zero. In a cycle after no command, `res_valid`, `res_legal` and `res_viol` are all 0.
- R2: After reset, `res_valid` is 0 and all windows are closed, so the first command of every type is legal.
- R3: Burst codes on `cmd_burst` are 0 fixed 8-beat, 1 on-the-fly 8-beat, 2 on-the-fly chop-4 and 3 fixed chop-4. The internal write of a write command starts WL+2 clocks after it for code 3 and WL+4 clocks after it otherwise. A read earlier than max(4, ceil(7.5 ns / tCK)) clocks after that start sets violation bit 0.
- R4: A mode-register set fewer than 4 clocks after the previous mode-register set sets violation bit 1.
- R5: Any command other than a mode-register set that comes fewer than max(12, ceil(15 ns / tCK)) clocks after a mode-register set sets violation bit 2. A mode-register set is not subject to this gap.
- R6: Power-down entry fewer than RL+5 clocks after a read sets violation bit 3.
- R7: Power-down entry fewer than (internal write start offset of R3) + ceil(tWR / tCK) clocks after a write sets violation bit 4. That offset is WL+4, or WL+2 for fixed chop-4.
- R8: Power-down entry needs at least 1 clock after a precharge, and a breach sets violation bit 5. Power-down entry on the clock right after a precharge is therefore legal.
- R9: Every nanosecond limit is converted to clocks by rounding up. With tCK = 1.6 ns, a read 13 clocks after a fixed 8-beat write at WL=5 is illegal.
- R10: When several rules are broken by one command, all of their bits are set together.
- R11: Every valid command opens its windows whether it was legal or not. Code 7 is never flagged and opens no window.
- R12: A new window never shortens one that is still running. The counter keeps the larger of its remaining count and the new load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cmd_valid | input | 1 | A command is present this cycle |
| cmd_code | input | 3 | Command code (R1) |
| cmd_burst | input | 2 | Burst mode of a write (R3) |
| cfg_wl | input | CYC_W | Write latency in clocks |
| cfg_rl | input | CYC_W | Read latency in clocks |
| res_valid | output | 1 | Verdict for the previous cycle's command |
| res_legal | output | 1 | Previous command met every gap |
| res_viol | output | NRULE | One bit per broken rule |

## Verification
Each gap is probed on both sides of its boundary: one clock short of the limit must be flagged, and exactly at the limit must pass. This separates an off-by-one in the load value from a correct count. Writes are sent in fixed 8-beat, on-the-fly and fixed chop-4 modes, which tells the burst-dependent start offset apart from a constant offset. A second write sent right behind a longer one shows whether a reload can cut a running window short. Back-to-back mode-register set, write, read and power-down entry show whether several bits are reported together. The reserved code, sent inside an open window and just before a power-down entry, shows that it is neither flagged nor arms anything.

// File: rtl/dcs_pkg.sv
package dcs_pkg;

    localparam int NRULE = 6;

    localparam int RULE_WTR = 0;
    localparam int RULE_MRD = 1;
    localparam int RULE_MOD = 2;
    localparam int RULE_RPD = 3;
    localparam int RULE_WPD = 4;
    localparam int RULE_PPD = 5;

    typedef enum logic [2:0] {
        CMD_ACT = 3'd0,
        CMD_RD  = 3'd1,
        CMD_WR  = 3'd2,
        CMD_PRE = 3'd3,
        CMD_MRS = 3'd4,
        CMD_REF = 3'd5,
        CMD_PDE = 3'd6,
        CMD_RSV = 3'd7
    } cmd_e;

    typedef enum logic [1:0] {
        BM_BL8_FIX = 2'd0,
        BM_BL8_OTF = 2'd1,
        BM_BC4_OTF = 2'd2,
        BM_BC4_FIX = 2'd3
    } burst_e;

    typedef logic [NRULE-1:0] rule_vec_t;

    typedef struct packed {
        rule_vec_t load_en;   // rules whose window this command opens
        rule_vec_t applies;   // rules that govern this command
    } rule_sel_t;

    function automatic int ceil_div(input int num, input int den);
        return (num + den - 1) / den;
    endfunction

    function automatic int max_int(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    // clocks from write latency to start of the internal write
    function automatic logic [2:0] wr_start_gap(input burst_e b);
        return (b == BM_BC4_FIX) ? 3'd2 : 3'd4;
    endfunction

endpackage

// File: rtl/dcs_rule_decode.sv
module dcs_rule_decode
    import dcs_pkg::*;
(
    input  logic      valid,
    input  cmd_e      code,
    output rule_sel_t sel
);
    always_comb begin
        sel = '0;
        if (valid) begin
            unique case (code)
                CMD_RD: begin
                    sel.applies[RULE_WTR] = 1'b1;
                    sel.applies[RULE_MOD] = 1'b1;
                    sel.load_en[RULE_RPD] = 1'b1;
                end
                CMD_WR: begin
                    sel.applies[RULE_MOD] = 1'b1;
                    sel.load_en[RULE_WTR] = 1'b1;
                    sel.load_en[RULE_WPD] = 1'b1;
                end
                CMD_PRE: begin
                    sel.applies[RULE_MOD] = 1'b1;
                    sel.load_en[RULE_PPD] = 1'b1;
                end
                CMD_MRS: begin
                    sel.applies[RULE_MRD] = 1'b1;
                    sel.load_en[RULE_MRD] = 1'b1;
                    sel.load_en[RULE_MOD] = 1'b1;
                end
                CMD_PDE: begin
                    sel.applies[RULE_MOD] = 1'b1;
                    sel.applies[RULE_RPD] = 1'b1;
                    sel.applies[RULE_WPD] = 1'b1;
                    sel.applies[RULE_PPD] = 1'b1;
                end
                CMD_ACT, CMD_REF: begin
                    sel.applies[RULE_MOD] = 1'b1;
                end
                default: begin
                    sel = '0;   // reserved code: ignored
                end
            endcase
        end
    end
endmodule

// File: rtl/dcs_load_calc.sv
module dcs_load_calc
    import dcs_pkg::*;
#(
    parameter int CYC_W       = 5,
    parameter int CNT_W       = 8,
    parameter int TCK_PS      = 1600,
    parameter int TWTR_PS     = 7500,
    parameter int TWTR_MIN_CK = 4,
    parameter int TMOD_PS     = 15000,
    parameter int TMOD_MIN_CK = 12,
    parameter int TMRD_CK     = 4,
    parameter int TWR_PS      = 15000,
    parameter int RD_PD_EXTRA = 5,
    parameter int TPRPDEN_CK  = 1
) (
    input  logic [CYC_W-1:0] wl,
    input  logic [CYC_W-1:0] rl,
    input  burst_e           burst,
    output logic [CNT_W-1:0] load_val [NRULE]
);
    localparam int WTR_CK = max_int(TWTR_MIN_CK, ceil_div(TWTR_PS, TCK_PS));
    localparam int MOD_CK = max_int(TMOD_MIN_CK, ceil_div(TMOD_PS, TCK_PS));
    localparam int WR_CK  = ceil_div(TWR_PS, TCK_PS);

    // a gap of N clocks is held by a counter loaded with N-1
    localparam logic [CNT_W-1:0] WTR_TAIL = CNT_W'(WTR_CK - 1);
    localparam logic [CNT_W-1:0] WR_TAIL  = CNT_W'(WR_CK - 1);
    localparam logic [CNT_W-1:0] MRD_LD   = CNT_W'(TMRD_CK - 1);
    localparam logic [CNT_W-1:0] MOD_LD   = CNT_W'(MOD_CK - 1);
    localparam logic [CNT_W-1:0] RPD_TAIL = CNT_W'(RD_PD_EXTRA - 1);
    localparam logic [CNT_W-1:0] PPD_LD   = CNT_W'(TPRPDEN_CK - 1);

    logic [CNT_W-1:0] wl_x;
    logic [CNT_W-1:0] rl_x;
    logic [CNT_W-1:0] wr_start;

    always_comb begin
        wl_x     = CNT_W'(wl);
        rl_x     = CNT_W'(rl);
        wr_start = wl_x + CNT_W'(wr_start_gap(burst));

        load_val[RULE_WTR] = wr_start + WTR_TAIL;
        load_val[RULE_MRD] = MRD_LD;
        load_val[RULE_MOD] = MOD_LD;
        load_val[RULE_RPD] = rl_x + RPD_TAIL;
        load_val[RULE_WPD] = wr_start + WR_TAIL;
        load_val[RULE_PPD] = PPD_LD;
    end
endmodule

// File: rtl/dcs_gap_counter.sv
module dcs_gap_counter #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load_en,
    input  logic [CNT_W-1:0] load_val,
    output logic             busy
);
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] dec;

    always_comb begin
        dec = (cnt == '0) ? '0 : cnt - {{(CNT_W-1){1'b0}}, 1'b1};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (load_en && (load_val > dec)) begin
            cnt <= load_val;
        end else begin
            cnt <= dec;
        end
    end

    assign busy = (cnt != '0);
endmodule

// File: rtl/dram_cmd_spacing_chk.sv
module dram_cmd_spacing_chk
    import dcs_pkg::*;
#(
    parameter int CYC_W   = 5,
    parameter int CNT_W   = 8,
    parameter int TCK_PS  = 1600,
    parameter int TWTR_PS = 7500,
    parameter int TMOD_PS = 15000,
    parameter int TWR_PS  = 15000
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cmd_valid,
    input  logic [2:0]       cmd_code,
    input  logic [1:0]       cmd_burst,
    input  logic [CYC_W-1:0] cfg_wl,
    input  logic [CYC_W-1:0] cfg_rl,
    output logic             res_valid,
    output logic             res_legal,
    output logic [NRULE-1:0] res_viol
);
    rule_sel_t        sel;
    logic [CNT_W-1:0] loads [NRULE];
    rule_vec_t        busy;
    rule_vec_t        viol_now;

    dcs_rule_decode u_dec (
        .valid (cmd_valid),
        .code  (cmd_e'(cmd_code)),
        .sel   (sel)
    );

    dcs_load_calc #(
        .CYC_W   (CYC_W),
        .CNT_W   (CNT_W),
        .TCK_PS  (TCK_PS),
        .TWTR_PS (TWTR_PS),
        .TMOD_PS (TMOD_PS),
        .TWR_PS  (TWR_PS)
    ) u_calc (
        .wl       (cfg_wl),
        .rl       (cfg_rl),
        .burst    (burst_e'(cmd_burst)),
        .load_val (loads)
    );

    for (genvar g = 0; g < NRULE; g++) begin : g_rule
        dcs_gap_counter #(.CNT_W(CNT_W)) u_cnt (
            .clk      (clk),
            .rst      (rst),
            .load_en  (sel.load_en[g]),
            .load_val (loads[g]),
            .busy     (busy[g])
        );
    end

    assign viol_now = busy & sel.applies;

    always_ff @(posedge clk) begin
        if (rst) begin
            res_valid <= 1'b0;
            res_legal <= 1'b0;
            res_viol  <= '0;
        end else begin
            res_valid <= cmd_valid;
            res_legal <= cmd_valid && (viol_now == '0);
            res_viol  <= cmd_valid ? viol_now : '0;
        end
    end
endmodule

// File: rtl/dcs_checker.sv
module dcs_checker
    import dcs_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             cmd_valid,
    input logic [2:0]       cmd_code,
    input logic             res_valid,
    input logic             res_legal,
    input logic [NRULE-1:0] res_viol
);
    assert_verdict_follows_R1: assert property (@(posedge clk) disable iff (rst)
        cmd_valid |=> res_valid);

    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (rst)
        !cmd_valid |=> (!res_valid && !res_legal && res_viol == '0));

    assert_rd_after_wr_R3: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_code == CMD_WR ##1 cmd_valid && cmd_code == CMD_RD)
        |=> res_viol[RULE_WTR]);

    assert_mrs_pair_R4: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_code == CMD_MRS ##1 cmd_valid && cmd_code == CMD_MRS)
        |=> (res_viol[RULE_MRD] && !res_viol[RULE_MOD]));

    assert_pde_after_rd_R6: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_code == CMD_RD ##1 cmd_valid && cmd_code == CMD_PDE)
        |=> res_viol[RULE_RPD]);

    assert_pde_after_pre_R8: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_code == CMD_PRE ##1 cmd_valid && cmd_code == CMD_PDE)
        |=> !res_viol[RULE_PPD]);

    assert_reserved_legal_R11: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_code == CMD_RSV) |=> (res_legal && res_viol == '0));
endmodule

bind dram_cmd_spacing_chk dcs_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .cmd_valid (cmd_valid),
    .cmd_code  (cmd_code),
    .res_valid (res_valid),
    .res_legal (res_legal),
    .res_viol  (res_viol)
);

// File: tb/dram_cmd_spacing_chk_bench.sv
module dram_cmd_spacing_chk_bench;
    localparam logic [2:0] C_ACT = 3'd0, C_RD = 3'd1, C_WR = 3'd2, C_PRE = 3'd3,
                           C_MRS = 3'd4, C_REF = 3'd5, C_PDE = 3'd6, C_RSV = 3'd7;
    localparam logic [1:0] B_BL8F = 2'd0, B_BL8O = 2'd1, B_BC4O = 2'd2, B_BC4F = 2'd3;
    localparam logic [5:0] V_WTR = 6'd1, V_MRD = 6'd2, V_MOD = 6'd4,
                           V_RPD = 6'd8, V_WPD = 6'd16, V_PPD = 6'd32;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cmd_valid = 1'b0;
    logic [2:0] cmd_code = 3'd0;
    logic [1:0] cmd_burst = 2'd0;
    logic [4:0] cfg_wl = 5'd5;
    logic [4:0] cfg_rl = 5'd6;
    logic       res_valid;
    logic       res_legal;
    logic [5:0] res_viol;

    int  n_chk  = 0;
    int  n_fail = 0;
    bit  done   = 0;

    always #2 clk = ~clk;   // 250 MHz

    dram_cmd_spacing_chk u_dram_cmd_spacing_chk (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
        .cmd_burst(cmd_burst), .cfg_wl(cfg_wl), .cfg_rl(cfg_rl),
        .res_valid(res_valid), .res_legal(res_legal), .res_viol(res_viol)
    );

    // issue one command at the current falling edge, check its verdict one falling edge later
    task automatic send(input logic [2:0] c, input logic [1:0] b,
                        input logic [5:0] exp, input string req);
        cmd_valid = 1'b1;
        cmd_code  = c;
        cmd_burst = b;
        @(negedge clk);
        cmd_valid = 1'b0;
        n_chk++;
        if (!res_valid || res_viol != exp || res_legal != (exp == 6'd0)) begin
            n_fail++;
            $display("FAIL %s: cmd %0d got valid=%0b legal=%0b viol=%06b, expected valid=1 legal=%0b viol=%06b",
                     req, c, res_valid, res_legal, res_viol, (exp == 6'd0), exp);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic t_reset;
        rst = 1'b1;
        idle(3);
        rst = 1'b0;
        idle(1);
        n_chk++;
        if (res_valid || res_legal || res_viol != 6'd0) begin
            n_fail++;
            $display("FAIL R2: after reset valid=%0b legal=%0b viol=%06b, expected 0 0 000000",
                     res_valid, res_legal, res_viol);
        end
        // first command of each type is legal (R2)
        send(C_PDE, B_BL8F, 6'd0, "R2");
        send(C_RD,  B_BL8F, 6'd0, "R2");
        send(C_ACT, B_BL8F, 6'd0, "R2");
        send(C_PRE, B_BL8F, 6'd0, "R2");
        send(C_REF, B_BL8F, 6'd0, "R2");
        send(C_WR,  B_BL8F, 6'd0, "R2");
        send(C_MRS, B_BL8F, 6'd0, "R2");
        idle(40);
        n_chk++;
        if (res_valid || res_legal || res_viol != 6'd0) begin
            n_fail++;
            $display("FAIL R1: idle outputs valid=%0b legal=%0b viol=%06b, expected 0 0 000000",
                     res_valid, res_legal, res_viol);
        end
    endtask

    // WL=5, tCK 1.6 ns: tWTR = 5 clocks, so the gap is 14 (8-beat) or 12 (fixed chop-4)
    task automatic t_wtr;
        send(C_WR, B_BL8F, 6'd0, "R3");
        idle(12);
        send(C_RD, B_BL8F, V_WTR, "R9");   // 13 clocks: needs rounding up
        send(C_RD, B_BL8F, 6'd0,  "R3");   // 14 clocks
        idle(40);
        send(C_WR, B_BC4F, 6'd0, "R3");
        idle(10);
        send(C_RD, B_BL8F, V_WTR, "R3");   // 11 clocks
        send(C_RD, B_BL8F, 6'd0,  "R3");   // 12 clocks
        idle(40);
        send(C_WR, B_BC4O, 6'd0, "R3");
        idle(12);
        send(C_RD, B_BL8F, V_WTR, "R3");
        send(C_RD, B_BL8F, 6'd0,  "R3");
        idle(40);
        send(C_WR, B_BL8O, 6'd0, "R3");
        idle(13);
        send(C_RD, B_BL8F, 6'd0, "R3");
        idle(40);
    endtask

    task automatic t_mrs;
        send(C_MRS, B_BL8F, 6'd0, "R4");
        idle(2);
        send(C_MRS, B_BL8F, V_MRD, "R4");  // 3 clocks
        idle(3);
        send(C_MRS, B_BL8F, 6'd0, "R4");   // 4 clocks, not subject to tMOD
        idle(10);
        send(C_ACT, B_BL8F, V_MOD, "R5");  // 11 clocks
        send(C_ACT, B_BL8F, 6'd0,  "R5");  // 12 clocks
        idle(40);
    endtask

    task automatic t_powerdown;
        send(C_RD, B_BL8F, 6'd0, "R6");
        idle(9);
        send(C_PDE, B_BL8F, V_RPD, "R6");  // 10 clocks, RL+5 = 11
        send(C_PDE, B_BL8F, 6'd0,  "R6");
        idle(40);
        send(C_WR, B_BL8F, 6'd0, "R7");
        idle(17);
        send(C_PDE, B_BL8F, V_WPD, "R7");  // 18 clocks, 5+4+10 = 19
        send(C_PDE, B_BL8F, 6'd0,  "R7");
        idle(40);
        send(C_WR, B_BC4F, 6'd0, "R7");
        idle(15);
        send(C_PDE, B_BL8F, V_WPD, "R7");  // 16 clocks, 5+2+10 = 17
        send(C_PDE, B_BL8F, 6'd0,  "R7");
        idle(40);
        send(C_PRE, B_BL8F, 6'd0, "R8");
        send(C_PDE, B_BL8F, 6'd0, "R8");
        idle(40);
    endtask

    task automatic t_multi;
        send(C_MRS, B_BL8F, 6'd0, "R10");
        send(C_WR,  B_BL8F, V_MOD, "R10");
        send(C_RD,  B_BL8F, V_MOD | V_WTR, "R10");
        send(C_PDE, B_BL8F, V_MOD | V_RPD | V_WPD, "R10");
        idle(40);
    endtask

    task automatic t_reserved;
        send(C_MRS, B_BL8F, 6'd0, "R11");
        send(C_RSV, B_BL8F, 6'd0, "R11");  // inside tMOD window, still not flagged
        idle(40);
        send(C_RSV, B_BL8F, 6'd0, "R11");
        send(C_PDE, B_BL8F, 6'd0, "R11");  // reserved opened no window
        idle(40);
    endtask

    task automatic t_no_shorten;
        send(C_WR, B_BL8F, 6'd0, "R12");   // read allowed 14 clocks later
        send(C_WR, B_BC4F, 6'd0, "R12");   // would allow it 13 clocks after the first
        idle(11);
        send(C_RD, B_BL8F, V_WTR, "R12");  // 13 after first, 12 after second
        send(C_RD, B_BL8F, 6'd0,  "R12");
        idle(40);
    endtask

    initial begin
        @(negedge clk);
        t_reset;
        t_wtr;
        t_mrs;
        t_powerdown;
        t_multi;
        t_reserved;
        t_no_shorten;
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: run did not complete, got timeout, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end
endmodule